// File: doc/BRIEF.md
# Duty-Cycled Receiver Wake-Up Sequencer

This block runs the polling mode of a low-power radio receiver. While polling is enabled it keeps the receiver asleep for a programmable time. It then wakes the receiver through two back-to-back intervals. The first is a recovery interval that gives the host processor time to wake. The second is a settle interval: the RF section is powered, but the peak detectors and the data outputs stay gated off. The host acknowledges a wake-up by pulling the data line low at any point across those two intervals. If it does, the block enters an active receive state. If it does not, the block goes back to sleep and starts the cycle again.

All interval lengths are counted in base periods. A base period is built from a 100 kHz tick, obtained by dividing the system clock by a programmed divisor, and then scaled by a prescaler. Each time the block enters the settle interval it raises a calibration request, which the analog side answers with a done pulse. Software can also start a calibration through the configuration register. That start bit clears itself when calibration completes and leaves a sticky completion flag behind.

Top module: `rx_poll_seq`

## Requirements
- R1: After reset the sequencer reports the sleep state (state codes: 0 sleep, 1 recovery, 2 settle, 3 active), all timer, divisor and configuration registers read as zero, and `rx_pwr_en`, `det_en`, `cal_req` and `cal_flag` are low.
- R2: The sleep interval lasts max(OFF,1) x B x max(DIV,1) clock cycles. OFF is the 16-bit value whose upper byte is written at address 0x4 and whose lower byte is written at 0x5. B is 1, 4, 16 or 64 for prescale codes 0, 1, 2 or 3. After sleep the state moves to recovery.
- R3: The recovery interval lasts max(CPU,1) x B x max(DIV,1) cycles. CPU is the 8-bit value at address 0x6. After recovery the state moves to settle.
- R4: The settle interval lasts max(RF,1) x B x max(DIV,1) cycles. RF is the 16-bit value whose upper byte is at address 0x7 and whose lower byte is at 0x8.
- R5: `rx_pwr_en` is high only in the settle and active states. `det_en` is high only in the active state.
- R6: If the synchronized data line is low in at least one cycle of the recovery or settle interval, the state moves to active when settle ends. Otherwise it returns to sleep.
- R7: A low level on the data line that is seen only during sleep does not count as an acknowledge.
- R8: A `host_release` pulse in the active state returns the block to sleep. Clearing the polling-enable bit puts the block in sleep, from any state, one cycle after the register write takes effect, and holds it there.
- R9: `cal_req` rises on entry to the settle interval. It falls in the cycle after a `cal_done` pulse.
- R10: Writing the configuration register with bit 1 set raises `cal_req` and clears `cal_flag`. A `cal_done` pulse then drops `cal_req` and sets `cal_flag`, which stays set.
- R11: The configuration register is at address 0x1: bit 0 enables polling, bit 1 starts a calibration, and bits 3:2 hold the prescale code. The clock divisor is at address 0x3, and a divisor of zero acts as one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| cal_done | input | 1 | One-cycle pulse from the analog side when calibration ends |
| data_line | input | 1 | Data line level, asynchronous; low means host acknowledge |
| host_release | input | 1 | Host request to leave the active state |
| rx_pwr_en | output | 1 | Receiver power enable |
| det_en | output | 1 | Peak detector and data output enable |
| cal_req | output | 1 | Calibration request (automatic or software) |
| cal_flag | output | 1 | Sticky calibration-complete flag |
| seq_state | output | 2 | Current sequencer state code |

## Verification
The bench measures every interval in clock cycles under several divisor and prescale settings. This includes a zero divisor, zero timer values, and a settle value that uses both bytes. A wrong byte order, a missing zero-as-one rule, or a timer that counts on from the previous state would give a visibly wrong interval length. The bench drives the data line low only during sleep and only during the window, to show that the acknowledge is honoured inside the window and ignored outside it. A design that latched the acknowledge too early or too late would either enter the active state wrongly or restart forever. The bench also clears polling mid-window and in the active state, and runs a software calibration. A non-clearing start bit, or a flag that is not sticky, would be reported there.

// File: rtl/rx_poll_pkg.sv
`timescale 1ns/1ps
package rx_poll_pkg;

   typedef enum logic [1:0] {
      ST_SLEEP  = 2'd0,
      ST_CPU    = 2'd1,
      ST_RF     = 2'd2,
      ST_ACTIVE = 2'd3
   } seq_state_t;

   // register addresses
   localparam int unsigned ADR_CFG    = 1;
   localparam int unsigned ADR_DIV    = 3;
   localparam int unsigned ADR_OFF_HI = 4;
   localparam int unsigned ADR_OFF_LO = 5;
   localparam int unsigned ADR_CPU    = 6;
   localparam int unsigned ADR_RF_HI  = 7;
   localparam int unsigned ADR_RF_LO  = 8;

   // configuration bit positions
   localparam int unsigned CFG_POLL_BIT = 0;
   localparam int unsigned CFG_CAL_BIT  = 1;
   localparam int unsigned CFG_PRE_LSB  = 2;

endpackage

// File: rtl/rx_poll_regs.sv
`timescale 1ns/1ps
module rx_poll_regs
   import rx_poll_pkg::*;
#(
   parameter int unsigned ADDR_W   = 4,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned TIMER_W  = 16,
   parameter int unsigned CPU_W    = 8,
   parameter int unsigned DIV_W    = 8,
   parameter int unsigned PRE_SEL_W = 2
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [ADDR_W-1:0]    wr_addr,
   input  logic [DATA_W-1:0]    wr_data,
   input  logic                 cal_done,
   input  logic                 auto_pend,
   output logic                 poll_en,
   output logic [PRE_SEL_W-1:0] pre_sel,
   output logic [DIV_W-1:0]     div_val,
   output logic [TIMER_W-1:0]   off_val,
   output logic [CPU_W-1:0]     cpu_val,
   output logic [TIMER_W-1:0]   rf_val,
   output logic                 sw_cal,
   output logic                 cal_flag
);

   logic hit_cfg, hit_div, hit_off_hi, hit_off_lo, hit_cpu, hit_rf_hi, hit_rf_lo;
   logic cal_start;

   assign hit_cfg    = wr_en && (wr_addr == ADDR_W'(ADR_CFG));
   assign hit_div    = wr_en && (wr_addr == ADDR_W'(ADR_DIV));
   assign hit_off_hi = wr_en && (wr_addr == ADDR_W'(ADR_OFF_HI));
   assign hit_off_lo = wr_en && (wr_addr == ADDR_W'(ADR_OFF_LO));
   assign hit_cpu    = wr_en && (wr_addr == ADDR_W'(ADR_CPU));
   assign hit_rf_hi  = wr_en && (wr_addr == ADDR_W'(ADR_RF_HI));
   assign hit_rf_lo  = wr_en && (wr_addr == ADDR_W'(ADR_RF_LO));
   assign cal_start  = hit_cfg && wr_data[CFG_CAL_BIT];

   // plain configuration and timer storage
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         poll_en <= 1'b0;
         pre_sel <= '0;
         div_val <= '0;
         off_val <= '0;
         cpu_val <= '0;
         rf_val  <= '0;
      end else begin
         if (hit_cfg) begin
            poll_en <= wr_data[CFG_POLL_BIT];
            pre_sel <= wr_data[CFG_PRE_LSB +: PRE_SEL_W];
         end
         if (hit_div)    div_val <= wr_data[DIV_W-1:0];
         if (hit_off_hi) off_val[DATA_W +: DATA_W] <= wr_data;
         if (hit_off_lo) off_val[0 +: DATA_W]      <= wr_data;
         if (hit_cpu)    cpu_val <= wr_data[CPU_W-1:0];
         if (hit_rf_hi)  rf_val[DATA_W +: DATA_W]  <= wr_data;
         if (hit_rf_lo)  rf_val[0 +: DATA_W]       <= wr_data;
      end
   end

   // self-clearing software start and sticky completion flag
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sw_cal   <= 1'b0;
         cal_flag <= 1'b0;
      end else begin
         if (cal_start)     sw_cal <= 1'b1;
         else if (cal_done) sw_cal <= 1'b0;

         if (cal_start)                             cal_flag <= 1'b0;
         else if (cal_done && (sw_cal || auto_pend)) cal_flag <= 1'b1;
      end
   end

endmodule

// File: rtl/rx_poll_sync.sv
`timescale 1ns/1ps
module rx_poll_sync #(
   parameter int unsigned STAGES    = 2,
   parameter logic        RESET_VAL = 1'b1
)(
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   if (STAGES == 1) begin : g_single
      logic stg;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg <= RESET_VAL;
         else        stg <= d;
      end
      assign q = stg;
   end else begin : g_chain
      logic [STAGES-1:0] stg;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg <= {STAGES{RESET_VAL}};
         else        stg <= {stg[STAGES-2:0], d};
      end
      assign q = stg[STAGES-1];
   end

endmodule

// File: rtl/rx_poll_timebase.sv
`timescale 1ns/1ps
module rx_poll_timebase #(
   parameter int unsigned DIV_W     = 8,
   parameter int unsigned CNT_W     = 16,
   parameter int unsigned PRE_LOG   = 2,
   parameter int unsigned PRE_CODES = 4,
   localparam int unsigned PRE_SEL_W = $clog2(PRE_CODES),
   localparam int unsigned PRE_W     = (PRE_LOG * (PRE_CODES - 1) > 0) ? PRE_LOG * (PRE_CODES - 1) : 1
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clear,
   input  logic [DIV_W-1:0]     div_val,
   input  logic [PRE_SEL_W-1:0] pre_sel,
   input  logic [CNT_W-1:0]     target,
   output logic                 expire
);

   logic [DIV_W-1:0] div_cnt, div_lim;
   logic [PRE_W-1:0] pre_cnt, pre_lim;
   logic [CNT_W-1:0] ivl_cnt, tgt_lim;
   logic             tick, base_hit;

   // zero values behave as one
   assign div_lim = (div_val == '0) ? '0 : div_val - 1'b1;
   assign tgt_lim = (target  == '0) ? '0 : target  - 1'b1;

   // prescale code k selects 2^(PRE_LOG*k) ticks per base period
   always_comb begin
      pre_lim = '0;
      for (int k = 0; k < PRE_CODES; k++) begin
         if (pre_sel == PRE_SEL_W'(k)) pre_lim = PRE_W'((1 << (PRE_LOG * k)) - 1);
      end
   end

   assign tick     = (div_cnt == div_lim);
   assign base_hit = tick && (pre_cnt == pre_lim);
   assign expire   = base_hit && (ivl_cnt == tgt_lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_cnt <= '0;
         pre_cnt <= '0;
         ivl_cnt <= '0;
      end else if (clear) begin
         div_cnt <= '0;
         pre_cnt <= '0;
         ivl_cnt <= '0;
      end else begin
         div_cnt <= tick ? '0 : div_cnt + 1'b1;
         if (tick)     pre_cnt <= base_hit ? '0 : pre_cnt + 1'b1;
         if (base_hit) ivl_cnt <= ivl_cnt + 1'b1;
      end
   end

endmodule

// File: rtl/rx_poll_fsm.sv
`timescale 1ns/1ps
module rx_poll_fsm
   import rx_poll_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       poll_en,
   input  logic       expire,
   input  logic       line_low,
   input  logic       host_release,
   input  logic       cal_done,
   output seq_state_t state,
   output logic       clear,
   output logic       auto_pend,
   output logic       rx_pwr_en,
   output logic       det_en
);

   seq_state_t nxt;
   logic       ack_q;
   logic       in_window;

   assign in_window = (state == ST_CPU) || (state == ST_RF);

   always_comb begin
      nxt = state;
      if (!poll_en) begin
         nxt = ST_SLEEP;
      end else begin
         case (state)
            ST_SLEEP:  if (expire) nxt = ST_CPU;
            ST_CPU:    if (expire) nxt = ST_RF;
            ST_RF:     if (expire) nxt = (ack_q || line_low) ? ST_ACTIVE : ST_SLEEP;
            ST_ACTIVE: if (host_release) nxt = ST_SLEEP;
            default:   nxt = ST_SLEEP;
         endcase
      end
   end

   // interval counters restart on every state change and idle otherwise
   assign clear = (nxt != state) || !poll_en || (state == ST_ACTIVE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_SLEEP;
         ack_q     <= 1'b0;
         auto_pend <= 1'b0;
      end else begin
         state     <= nxt;
         ack_q     <= ((nxt == ST_CPU) || (nxt == ST_RF)) && (ack_q || (in_window && line_low));
         auto_pend <= (nxt == ST_RF) && ((state == ST_CPU) || (auto_pend && !cal_done));
      end
   end

   assign rx_pwr_en = (state == ST_RF) || (state == ST_ACTIVE);
   assign det_en    = (state == ST_ACTIVE);

endmodule

// File: rtl/rx_poll_seq.sv
`timescale 1ns/1ps
module rx_poll_seq
   import rx_poll_pkg::*;
#(
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned TIMER_W     = 16,
   parameter int unsigned CPU_W       = 8,
   parameter int unsigned DIV_W       = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned PRE_LOG     = 2,
   parameter int unsigned PRE_CODES   = 4
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              cal_done,
   input  logic              data_line,
   input  logic              host_release,
   output logic              rx_pwr_en,
   output logic              det_en,
   output logic              cal_req,
   output logic              cal_flag,
   output logic [1:0]        seq_state
);

   localparam int unsigned PRE_SEL_W = $clog2(PRE_CODES);

   // elaboration-time parameter checks
   if (TIMER_W != 2 * DATA_W) begin : g_bad_timer_w
      $error("TIMER_W must be two data bytes wide");
   end
   if (CPU_W > DATA_W || CPU_W < 1) begin : g_bad_cpu_w
      $error("CPU_W must fit in one data byte");
   end
   if (DIV_W > DATA_W || DIV_W < 1) begin : g_bad_div_w
      $error("DIV_W must fit in one data byte");
   end
   if (ADDR_W < 4) begin : g_bad_addr_w
      $error("ADDR_W too narrow for the register map");
   end
   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("SYNC_STAGES must be at least one");
   end
   if (PRE_CODES < 2 || (1 << PRE_SEL_W) != PRE_CODES) begin : g_bad_pre
      $error("PRE_CODES must be a power of two of at least two");
   end

   logic                 poll_en, sw_cal, auto_pend;
   logic [PRE_SEL_W-1:0] pre_sel;
   logic [DIV_W-1:0]     div_val;
   logic [TIMER_W-1:0]   off_val, rf_val, target;
   logic [CPU_W-1:0]     cpu_val;
   logic                 line_sync, line_low, clear, expire;
   seq_state_t           state;

   rx_poll_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TIMER_W(TIMER_W),
      .CPU_W(CPU_W), .DIV_W(DIV_W), .PRE_SEL_W(PRE_SEL_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .cal_done(cal_done), .auto_pend(auto_pend),
      .poll_en(poll_en), .pre_sel(pre_sel), .div_val(div_val),
      .off_val(off_val), .cpu_val(cpu_val), .rf_val(rf_val),
      .sw_cal(sw_cal), .cal_flag(cal_flag)
   );

   rx_poll_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(data_line), .q(line_sync)
   );
   assign line_low = !line_sync;

   // interval length follows the current state
   always_comb begin
      case (state)
         ST_SLEEP: target = off_val;
         ST_CPU:   target = TIMER_W'(cpu_val);
         ST_RF:    target = rf_val;
         default:  target = '0;
      endcase
   end

   rx_poll_timebase #(
      .DIV_W(DIV_W), .CNT_W(TIMER_W), .PRE_LOG(PRE_LOG), .PRE_CODES(PRE_CODES)
   ) u_tb (
      .clk(clk), .rst_n(rst_n), .clear(clear), .div_val(div_val),
      .pre_sel(pre_sel), .target(target), .expire(expire)
   );

   rx_poll_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .poll_en(poll_en), .expire(expire),
      .line_low(line_low), .host_release(host_release), .cal_done(cal_done),
      .state(state), .clear(clear), .auto_pend(auto_pend),
      .rx_pwr_en(rx_pwr_en), .det_en(det_en)
   );

   assign cal_req   = sw_cal || auto_pend;
   assign seq_state = state;

endmodule

// File: rtl/rx_poll_seq_chk.sv
`timescale 1ns/1ps
module rx_poll_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] seq_state,
   input logic       rx_pwr_en,
   input logic       det_en,
   input logic       cal_done,
   input logic       cal_flag,
   input logic       poll_en,
   input logic       host_release
);

   logic past_ok;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   p_sleep_exit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(seq_state) == 2'd0 && seq_state != 2'd0) |-> seq_state == 2'd1);

   p_cpu_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(seq_state) == 2'd1 && seq_state != 2'd1) |-> (seq_state == 2'd2 || seq_state == 2'd0));

   p_settle_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_state == 2'd2) |-> (rx_pwr_en && !det_en));

   p_sleep_dark_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_state == 2'd0 || seq_state == 2'd1) |-> (!rx_pwr_en && !det_en));

   p_active_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(seq_state) != 2'd3 && seq_state == 2'd3) |-> $past(seq_state) == 2'd2);

   p_disable_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !poll_en |=> seq_state == 2'd0);

   p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_state == 2'd3 && host_release) |=> seq_state == 2'd0);

   p_flag_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !$past(cal_flag) && cal_flag) |-> $past(cal_done));

endmodule

bind rx_poll_seq rx_poll_seq_chk u_chk (
   .clk(clk), .rst_n(rst_n), .seq_state(seq_state), .rx_pwr_en(rx_pwr_en),
   .det_en(det_en), .cal_done(cal_done), .cal_flag(cal_flag),
   .poll_en(poll_en), .host_release(host_release)
);

// File: tb/sim_rx_poll_seq.sv
`timescale 1ns/1ps
module sim_rx_poll_seq;

   logic       clk = 1'b0;
   logic       rst_n, wr_en, cal_done, data_line, host_release;
   logic [3:0] wr_addr;
   logic [7:0] wr_data;
   logic       rx_pwr_en, det_en, cal_req, cal_flag;
   logic [1:0] seq_state;

   int  n_chk = 0;
   int  n_fail = 0;
   bit  finished = 1'b0;
   bit  ack_mode = 1'b0;
   bit  force_low = 1'b0;
   bit  got_drop = 1'b0;
   bit  prev_req = 1'b0;

   always #10 clk = ~clk;

   rx_poll_seq u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .cal_done(cal_done), .data_line(data_line), .host_release(host_release),
      .rx_pwr_en(rx_pwr_en), .det_en(det_en), .cal_req(cal_req),
      .cal_flag(cal_flag), .seq_state(seq_state)
   );

   typedef struct packed {
      logic [1:0]  pre;
      logic [15:0] off;
      logic [7:0]  cpu;
      logic [15:0] rf;
      logic [7:0]  div;
      logic        ack;
      logic [31:0] exp_cpu;
      logic [31:0] exp_rf;
      logic [31:0] exp_sleep;
   } vec_t;

   localparam int NVEC = 6;
   localparam vec_t VECS [NVEC] = '{
      '{2'd0, 16'd5,   8'd6,  16'd8,   8'd1, 1'b1, 32'd6,  32'd8,   32'd5},
      '{2'd1, 16'd3,   8'd2,  16'd3,   8'd2, 1'b0, 32'd16, 32'd24,  32'd24},
      '{2'd2, 16'd0,   8'd1,  16'd1,   8'd1, 1'b1, 32'd16, 32'd16,  32'd16},
      '{2'd3, 16'd2,   8'd0,  16'd1,   8'd0, 1'b0, 32'd64, 32'd64,  32'd128},
      '{2'd0, 16'd300, 8'd10, 16'd258, 8'd3, 1'b1, 32'd30, 32'd774, 32'd900},
      '{2'd1, 16'd1,   8'd3,  16'd2,   8'd5, 1'b0, 32'd60, 32'd40,  32'd20}
   };

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input int addr, input logic [7:0] data);
      wr_en   = 1'b1;
      wr_addr = 4'(addr);
      wr_data = data;
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   task automatic wait_state(input logic [1:0] s);
      while (seq_state !== s) @(negedge clk);
   endtask

   task automatic run_len(input logic [1:0] s, output int n);
      n = 0;
      while (seq_state === s) begin
         n++;
         @(negedge clk);
      end
   endtask

   // data line: low across the recovery interval when an acknowledge is planned
   initial forever begin
      @(negedge clk);
      data_line = !((ack_mode && seq_state == 2'd1) || force_low);
   end

   // calibration responder
   initial forever begin
      @(negedge clk);
      if (cal_req && !cal_done) begin
         repeat (2) @(negedge clk);
         cal_done = 1'b1;
         @(negedge clk);
         cal_done = 1'b0;
      end
   end

   // watches cal_req falling inside the settle interval
   initial forever begin
      @(negedge clk);
      if (seq_state == 2'd2 && prev_req && !cal_req) got_drop = 1'b1;
      prev_req = cal_req;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int n;
      rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
      cal_done = 1'b0; data_line = 1'b1; host_release = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 state", seq_state, 0);
      chk("R1 rx_pwr_en", rx_pwr_en, 0);
      chk("R1 det_en", det_en, 0);
      chk("R1 cal_req", cal_req, 0);
      chk("R1 cal_flag", cal_flag, 0);
      repeat (40) @(negedge clk);
      chk("R8 idle while polling off", seq_state, 0);

      // vector table
      for (int i = 0; i < NVEC; i++) begin
         vec_t v;
         v = VECS[i];
         wr(1, {4'b0, v.pre, 2'b00});          // R11 config with polling off
         wr(3, v.div);
         wr(4, v.off[15:8]);
         wr(5, v.off[7:0]);
         wr(6, v.cpu);
         wr(7, v.rf[15:8]);
         wr(8, v.rf[7:0]);
         ack_mode = v.ack;
         wr(1, {4'b0, v.pre, 2'b01});
         wait_state(2'd1);
         chk("R5 power off in recovery", rx_pwr_en, 0);
         run_len(2'd1, n);
         chk("R3 recovery length", n, int'(v.exp_cpu));
         chk("R3 recovery to settle", seq_state, 2);
         chk("R5 power in settle", rx_pwr_en, 1);
         chk("R5 detectors gated in settle", det_en, 0);
         chk("R9 cal_req on settle entry", cal_req, 1);
         got_drop = 1'b0;
         run_len(2'd2, n);
         chk("R4 settle length", n, int'(v.exp_rf));
         chk("R9 cal_req dropped after done", got_drop, 1);
         if (v.ack) begin
            chk("R6 acknowledged to active", seq_state, 3);
            chk("R5 detectors on in active", det_en, 1);
            ack_mode = 1'b0;
            repeat (3) @(negedge clk);
            chk("R8 active holds", seq_state, 3);
            host_release = 1'b1;
            @(negedge clk);
            host_release = 1'b0;
            chk("R8 release to sleep", seq_state, 0);
         end else begin
            chk("R6 no acknowledge restarts", seq_state, 0);
         end
         chk("R5 power off in sleep", rx_pwr_en, 0);
         run_len(2'd0, n);
         chk("R2 sleep length", n, int'(v.exp_sleep));
         chk("R2 sleep to recovery", seq_state, 1);
         wr(1, 8'h00);
         @(negedge clk);
         chk("R8 disable in recovery", seq_state, 0);
      end

      // R7: low level seen only during sleep
      wr(3, 8'd1); wr(4, 8'd0); wr(5, 8'd30); wr(6, 8'd4); wr(7, 8'd0); wr(8, 8'd6);
      wr(1, 8'h01);
      force_low = 1'b1;
      repeat (6) @(negedge clk);
      force_low = 1'b0;
      chk("R7 still asleep", seq_state, 0);
      wait_state(2'd2);
      run_len(2'd2, n);
      chk("R7 sleep-time low ignored", seq_state, 0);

      // R8: disable mid-window and in active
      wait_state(2'd1);
      wr(1, 8'h00);
      @(negedge clk);
      chk("R8 disable mid-window", seq_state, 0);
      repeat (100) @(negedge clk);
      chk("R8 held in sleep", seq_state, 0);
      chk("R8 held powered down", rx_pwr_en, 0);
      ack_mode = 1'b1;
      wr(1, 8'h01);
      wait_state(2'd3);
      ack_mode = 1'b0;
      wr(1, 8'h00);
      @(negedge clk);
      chk("R8 disable in active", seq_state, 0);
      chk("R8 detectors off after disable", det_en, 0);

      // R10: software calibration
      repeat (5) @(negedge clk);
      wr(1, 8'h02);
      chk("R10 cal_req after start", cal_req, 1);
      chk("R10 flag cleared by start", cal_flag, 0);
      repeat (5) @(negedge clk);
      chk("R10 start bit self-clears", cal_req, 0);
      chk("R10 flag set", cal_flag, 1);
      repeat (20) @(negedge clk);
      chk("R10 flag sticky", cal_flag, 1);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule